// File: doc/BRIEF.md
# Shadow Stack Instruction Permission Checker

This block is a purely combinational gate that sits between instruction decode and execute. Decode supplies an instruction class that is already known to be a shadow-stack instruction. The block also takes the current privilege mode and three enable bits: a machine-level enable, a hypervisor-level enable and a supervisor-level enable. From these it gives one verdict.

The instruction may run as a real shadow-stack operation. It may fall back to its may-be-operation meaning, which is a no-op style encoding. It may also trap as illegal-instruction or as virtual-instruction.

The enables form a chain, and the links that apply depend on the mode. Machine mode is never restricted. The 32-bit and 16-bit shadow-stack forms degrade quietly when their chain is off. The atomic shadow-stack swap cannot degrade, so it traps. The kind of trap depends on which link is missing and on whether the hart is virtualized.

Top module: `ssx_perm_check`

## Requirements
- R1: Encodings: mode M=0, S=1, U=2, VS=3, VU=4. Class 32-bit op=0, 16-bit op=1, swap=2. With `valid_i` high and a defined class and mode, exactly one of `exec_o`, `fallback_o`, `illegal_o`, `virtual_o` is high.
- R2: In mode M every class gives `exec_o`, whatever the enables are.
- R3: The chain is active when its enables are all set. S needs the machine enable. U needs the machine and supervisor enables. VS needs the machine and hypervisor enables. VU needs all three. When the chain is active, every class gives `exec_o`.
- R4: When the chain is inactive, the 32-bit and 16-bit classes give `fallback_o` and never trap.
- R5: A swap below M with the machine enable clear gives `illegal_o`. This wins over any virtual-instruction condition.
- R6: A swap with the machine enable set and the hypervisor enable clear gives `virtual_o` in VS and in VU.
- R7: A swap with the machine and hypervisor enables set and the supervisor enable clear gives `illegal_o` in U and `virtual_o` in VU.
- R8: With `valid_i` low, a reserved class (3), or a reserved mode (5 to 7), all four outputs are low.
- R9: An enable outside a mode's chain has no effect on that mode's verdict. The hypervisor enable does not affect S or U. The supervisor enable does not affect S or VS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Decoded shadow-stack instruction present |
| cls_i | input | 2 | Instruction class |
| priv_i | input | 3 | Current privilege mode including virtualization |
| m_en_i | input | 1 | Machine-level shadow-stack enable |
| h_en_i | input | 1 | Hypervisor-level shadow-stack enable |
| s_en_i | input | 1 | Supervisor-level shadow-stack enable |
| exec_o | output | 1 | Execute as a shadow-stack operation |
| fallback_o | output | 1 | Execute as a may-be-operation |
| illegal_o | output | 1 | Raise illegal-instruction |
| virtual_o | output | 1 | Raise virtual-instruction |

## Verification
The bench aims at the swap in U and VU with only the supervisor enable clear. A design that keys the trap type on the missing enable alone would report the same trap in both modes instead of illegal in U and virtual in VU.

It also drives a swap in VS and VU with the machine enable clear. A design that gives the virtual trap priority would report virtual there instead of illegal.

Machine mode is run with every enable clear, to catch a design that lets the enables leak into M. An exhaustive sweep covers the remaining cases. It includes the reserved class and mode codes, which must give no output, and the enables outside each mode's chain, which must not change the verdict.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  localparam int unsigned PRIV_W = 3;
  localparam int unsigned CLS_W  = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_M  = 3'd0,
    PRIV_S  = 3'd1,
    PRIV_U  = 3'd2,
    PRIV_VS = 3'd3,
    PRIV_VU = 3'd4
  } priv_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_OP32 = 2'd0,
    CLS_OP16 = 2'd1,
    CLS_SWAP = 2'd2
  } cls_e;

  typedef struct packed {
    logic exec;
    logic fallback;
    logic illegal;
    logic virt;
  } verdict_t;

endpackage

// File: rtl/ssx_mode_gate.sv
module ssx_mode_gate
  import ssx_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              m_en_i,
  input  logic              h_en_i,
  input  logic              s_en_i,
  output logic              known_o,
  output logic              chain_on_o
);

  always_comb begin
    known_o    = 1'b1;
    chain_on_o = 1'b0;
    unique case (priv_i)
      PRIV_M:  chain_on_o = 1'b1;
      PRIV_S:  chain_on_o = m_en_i;
      PRIV_U:  chain_on_o = m_en_i & s_en_i;
      PRIV_VS: chain_on_o = m_en_i & h_en_i;
      PRIV_VU: chain_on_o = m_en_i & h_en_i & s_en_i;
      default: known_o    = 1'b0;
    endcase
    // R3: chain never active below M without the machine enable
    if (known_o && priv_i != PRIV_M)
      p_chain_needs_m_r3: assert (!chain_on_o || m_en_i);
  end

endmodule

// File: rtl/ssx_swap_trap.sv
module ssx_swap_trap
  import ssx_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              m_en_i,
  input  logic              h_en_i,
  input  logic              s_en_i,
  output logic              illegal_o,
  output logic              virtual_o
);

  logic is_virt;

  // Only meaningful below M with the chain off.
  always_comb begin
    is_virt   = (priv_i == PRIV_VS) || (priv_i == PRIV_VU);
    illegal_o = 1'b0;
    virtual_o = 1'b0;
    if (!m_en_i) begin
      illegal_o = 1'b1;
    end else if (priv_i == PRIV_U) begin
      illegal_o = !s_en_i;
    end else if (is_virt) begin
      virtual_o = !h_en_i || (priv_i == PRIV_VU && !s_en_i);
    end
    p_trap_exclusive_r5: assert (!(illegal_o && virtual_o));
    p_virt_only_guest_r6: assert (!virtual_o || is_virt);
  end

endmodule

// File: rtl/ssx_perm_check.sv
module ssx_perm_check
  import ssx_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] cls_i,
  input  logic [2:0] priv_i,
  input  logic       m_en_i,
  input  logic       h_en_i,
  input  logic       s_en_i,
  output logic       exec_o,
  output logic       fallback_o,
  output logic       illegal_o,
  output logic       virtual_o
);

  logic     mode_known;
  logic     chain_on;
  logic     swap_ill;
  logic     swap_virt;
  logic     cls_known;
  logic     go;
  verdict_t vd;

  ssx_mode_gate i_mode_gate (
    .priv_i     (priv_i),
    .m_en_i     (m_en_i),
    .h_en_i     (h_en_i),
    .s_en_i     (s_en_i),
    .known_o    (mode_known),
    .chain_on_o (chain_on)
  );

  ssx_swap_trap i_swap_trap (
    .priv_i    (priv_i),
    .m_en_i    (m_en_i),
    .h_en_i    (h_en_i),
    .s_en_i    (s_en_i),
    .illegal_o (swap_ill),
    .virtual_o (swap_virt)
  );

  always_comb begin
    cls_known = (cls_i == CLS_OP32) || (cls_i == CLS_OP16) || (cls_i == CLS_SWAP);
    go        = valid_i && cls_known && mode_known;
    vd        = '0;
    if (go) begin
      if (chain_on)               vd.exec     = 1'b1;
      else if (cls_i != CLS_SWAP) vd.fallback = 1'b1;
      else begin
        vd.illegal = swap_ill;
        vd.virt    = swap_virt;
      end
    end
    p_onehot_r1: assert ($onehot0(vd) && (!go || $countones(vd) == 1));
    p_idle_r8:   assert (go || vd == '0);
    p_trap_swap_only_r4: assert (!(vd.illegal || vd.virt) || cls_i == CLS_SWAP);
    p_m_exec_r2: assert (!(go && priv_i == PRIV_M) || vd.exec);
  end

  assign exec_o     = vd.exec;
  assign fallback_o = vd.fallback;
  assign illegal_o  = vd.illegal;
  assign virtual_o  = vd.virt;

endmodule

// File: tb/test_ssx_perm_check.sv
module test_ssx_perm_check;

  typedef struct packed {
    logic [1:0] cls;
    logic [2:0] priv;
    logic [2:0] en;   // {m,h,s}
    logic [3:0] exp;  // {exec,fallback,illegal,virtual}
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 3'b000, 4'b1000},
    '{2'd2, 3'd0, 3'b000, 4'b1000},
    '{2'd0, 3'd1, 3'b100, 4'b1000},
    '{2'd0, 3'd1, 3'b000, 4'b0100},
    '{2'd1, 3'd1, 3'b000, 4'b0100},
    '{2'd2, 3'd1, 3'b000, 4'b0010},
    '{2'd2, 3'd1, 3'b111, 4'b1000},
    '{2'd0, 3'd2, 3'b101, 4'b1000},
    '{2'd1, 3'd2, 3'b100, 4'b0100},
    '{2'd2, 3'd2, 3'b100, 4'b0010},
    '{2'd2, 3'd2, 3'b011, 4'b0010},
    '{2'd2, 3'd3, 3'b110, 4'b1000},
    '{2'd2, 3'd3, 3'b101, 4'b0001},
    '{2'd1, 3'd3, 3'b101, 4'b0100},
    '{2'd2, 3'd3, 3'b011, 4'b0010},
    '{2'd2, 3'd4, 3'b111, 4'b1000},
    '{2'd2, 3'd4, 3'b110, 4'b0001},
    '{2'd2, 3'd4, 3'b101, 4'b0001},
    '{2'd2, 3'd4, 3'b011, 4'b0010},
    '{2'd0, 3'd4, 3'b110, 4'b0100},
    '{2'd1, 3'd4, 3'b111, 4'b1000},
    '{2'd2, 3'd2, 3'b101, 4'b1000},
    '{2'd1, 3'd1, 3'b100, 4'b1000},
    '{2'd2, 3'd3, 3'b111, 4'b1000}
  };

  logic clk = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] cls_i = '0;
  logic [2:0] priv_i = '0;
  logic m_en_i = 1'b0, h_en_i = 1'b0, s_en_i = 1'b0;
  logic exec_o, fallback_o, illegal_o, virtual_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ssx_perm_check i_ssx_perm_check (
    .valid_i(valid_i), .cls_i(cls_i), .priv_i(priv_i),
    .m_en_i(m_en_i), .h_en_i(h_en_i), .s_en_i(s_en_i),
    .exec_o(exec_o), .fallback_o(fallback_o),
    .illegal_o(illegal_o), .virtual_o(virtual_o)
  );

  // Reference from the requirements: returns {exec,fallback,illegal,virtual}
  function automatic logic [3:0] model(input logic v, input logic [1:0] c,
                                       input logic [2:0] p, input logic [2:0] e);
    logic m, h, s, on;
    m = e[2]; h = e[1]; s = e[0];
    if (!v || c == 2'd3 || p > 3'd4) return 4'b0000;
    case (p)
      3'd0: on = 1'b1;
      3'd1: on = m;
      3'd2: on = m & s;
      3'd3: on = m & h;
      default: on = m & h & s;
    endcase
    if (on) return 4'b1000;
    if (c != 2'd2) return 4'b0100;
    if (!m) return 4'b0010;
    if (p == 3'd2) return 4'b0010;  // U with supervisor enable clear
    return 4'b0001;                 // VS/VU guest-side link missing
  endfunction

  task automatic apply(input logic v, input logic [1:0] c, input logic [2:0] p,
                       input logic [2:0] e);
    @(negedge clk);
    valid_i = v; cls_i = c; priv_i = p;
    {m_en_i, h_en_i, s_en_i} = e;
    #1;
  endtask

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {exec_o, fallback_o, illegal_o, virtual_o};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cls=%0d priv=%0d en=%b got=%b exp=%b",
               tag, cls_i, priv_i, {m_en_i, h_en_i, s_en_i}, got, exp);
    end
  endtask

  initial begin
    // reset state: nothing presented, no verdict (R8)
    #2;
    check(4'b0000, "R8 idle");

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i].cls, VEC[i].priv, VEC[i].en);
      check(VEC[i].exp, "R1-table");
    end

    // R2 machine mode, no enables
    apply(1'b1, 2'd1, 3'd0, 3'b000); check(4'b1000, "R2 m op16");
    // R5 illegal beats virtual in guest modes
    apply(1'b1, 2'd2, 3'd4, 3'b000); check(4'b0010, "R5 vu swap");
    apply(1'b1, 2'd2, 3'd3, 3'b001); check(4'b0010, "R5 vs swap");
    // R6 hypervisor enable clear
    apply(1'b1, 2'd2, 3'd3, 3'b100); check(4'b0001, "R6 vs swap");
    // R7 supervisor enable clear: U illegal, VU virtual
    apply(1'b1, 2'd2, 3'd2, 3'b110); check(4'b0010, "R7 u swap");
    apply(1'b1, 2'd2, 3'd4, 3'b110); check(4'b0001, "R7 vu swap");
    // R4 fallback never traps
    apply(1'b1, 2'd0, 3'd4, 3'b000); check(4'b0100, "R4 vu op32");
    // R8 reserved codes and valid low
    apply(1'b0, 2'd2, 3'd2, 3'b000); check(4'b0000, "R8 invalid");
    apply(1'b1, 2'd3, 3'd1, 3'b111); check(4'b0000, "R8 cls3");
    apply(1'b1, 2'd0, 3'd6, 3'b111); check(4'b0000, "R8 priv6");
    // R9 out-of-chain enables ignored
    apply(1'b1, 2'd2, 3'd1, 3'b111); check(4'b1000, "R9 s h/s set");
    apply(1'b1, 2'd2, 3'd1, 3'b100); check(4'b1000, "R9 s h/s clear");
    apply(1'b1, 2'd2, 3'd2, 3'b101); check(4'b1000, "R9 u h clear");
    apply(1'b1, 2'd2, 3'd3, 3'b110); check(4'b1000, "R9 vs s clear");

    // exhaustive sweep (R1 R3 R4 R8 R9)
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 8; p++)
          for (int e = 0; e < 8; e++) begin
            apply(v[0], c[1:0], p[2:0], e[2:0]);
            check(model(v[0], c[1:0], p[2:0], e[2:0]), "R3 sweep");
          end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule